// File: doc/BRIEF.md
# Game Agent Behaviour Controller

This block chooses the current behaviour of a simulated game agent. On every rising clock edge it samples four condition flags (an enemy is in view, a sound is audible, the agent has died, health is low) and moves a registered behaviour state. The state, and one action strobe per behaviour class, are driven from that register only. No input reaches an output in the same cycle.

The sensed conditions are part of the state identity. Two attack states exist: a plain one, and one that remembers a sound was heard during the fight. When the enemy leaves view, the second one goes straight to chasing. Low health has its own states: two retreat states, one with a sound audible and one without, and a quiet wander state. Surrounding logic reads the strobes to run the matching action. Sensing, executing the action and any random wandering belong to that surrounding logic.

Parameter `ONEHOT_STATE` picks how the state is stored: a 3-bit binary code (0) or an 8-bit one-hot vector (1). The state code seen at the ports is the same in both cases.

Top module: `agent_behavior_fsm`

## Requirements
- R1: With health not low, no enemy in view and no sound audible, the next state is wander (code 0). This applies from every state except spawn and attack-with-sound, and only while dead is low.
- R2: With an enemy in view, health not low and dead low, the next state is attack (code 2). It is attack-with-sound (code 3) when a sound is audible or when the current state is already code 3.
- R3: With no enemy in view and a sound audible, the next state is chase (code 6) when dead is low and the current state is not spawn.
- R4: Dead high forces spawn (code 7) on the next edge from any state, spawn included. Dead takes priority over every other input.
- R5: Attack-with-sound (code 3) is kept while the enemy stays in view and health stays fine, even if the sound stops. From code 3, losing sight of the enemy while dead is low goes to chase (code 6), whether or not a sound is audible and whatever the health.
- R6: With an enemy in view, health low and dead low, the agent retreats rather than attacks. The next state is retreat (code 4) with no sound, and retreat-with-sound (code 5) with sound. This holds from any state other than spawn.
- R7: With health low, no enemy in view, no sound audible and dead low, the next state is low-health wander (code 1). This applies from every state except spawn and attack-with-sound.
- R8: Spawn lasts exactly one cycle when dead falls. The next state is wander (code 0), or low-health wander (code 1) if health is low. Enemy and sound are ignored for that transition.
- R9: Exactly one strobe is high in every cycle, decoded from the registered state. wander_o is high for codes 0 and 1, attack_o for codes 2 and 3, retreat_o for codes 4 and 5, chase_o for code 6 and spawn_o for code 7.
- R10: While rst_ni is low the state is wander (code 0) and wander_o is high.
- R11: The binary and one-hot storage variants give identical port behaviour for any input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enemy_seen_i | input | 1 | Enemy in view |
| sound_heard_i | input | 1 | Sound audible |
| dead_i | input | 1 | Agent has died |
| health_low_i | input | 1 | Health is low |
| state_o | output | 3 | Registered behaviour code |
| wander_o | output | 1 | Wander action strobe |
| attack_o | output | 1 | Attack action strobe |
| chase_o | output | 1 | Chase action strobe |
| retreat_o | output | 1 | Retreat action strobe |
| spawn_o | output | 1 | Spawn action strobe |

## Verification
The bench builds two instances side by side and drives both with the same inputs. One uses binary storage (`ONEHOT_STATE=0`) and the other one-hot storage (`ONEHOT_STATE=1`). Every cycle both are compared to the bench's model and to each other, so a fault in either storage variant or its decode shows up as a disagreement. Directed sequences cover the held sound memory, dead held during spawn, and leaving spawn with low health while an enemy is in view. Seeded random vectors, with dead kept rare, then reach every state from every other state.

// File: rtl/agent_pkg.sv
package agent_pkg;
  localparam int unsigned NUM_BEHAV = 8;
  localparam int unsigned STATE_W   = $clog2(NUM_BEHAV);
  localparam int unsigned NUM_ACT   = 5;

  typedef enum logic [STATE_W-1:0] {
    BH_WANDER      = 3'd0,
    BH_WANDER_LOW  = 3'd1,
    BH_ATTACK      = 3'd2,
    BH_ATTACK_SND  = 3'd3,
    BH_RETREAT     = 3'd4,
    BH_RETREAT_SND = 3'd5,
    BH_CHASE       = 3'd6,
    BH_SPAWN       = 3'd7
  } behav_e;

  typedef struct packed {
    logic enemy;
    logic sound;
    logic dead;
    logic low;
  } sense_t;

  typedef struct packed {
    logic wander;
    logic attack;
    logic chase;
    logic retreat;
    logic spawn;
  } act_t;
endpackage

// File: rtl/agent_next_state.sv
module agent_next_state
  import agent_pkg::*;
(
  input  behav_e cur_i,
  input  sense_t sense_i,
  output behav_e nxt_o
);
  behav_e quiet_wander;
  behav_e seen_target;
  logic   snd_memory;

  assign quiet_wander = sense_i.low ? BH_WANDER_LOW : BH_WANDER;
  assign snd_memory   = (cur_i == BH_ATTACK_SND);

  // low health retreats; otherwise attack, keeping the sound memory
  always_comb begin
    if (sense_i.low)
      seen_target = sense_i.sound ? BH_RETREAT_SND : BH_RETREAT;
    else if (sense_i.sound || snd_memory)
      seen_target = BH_ATTACK_SND;
    else
      seen_target = BH_ATTACK;
  end

  always_comb begin
    unique casez ({sense_i.dead, (cur_i == BH_SPAWN), sense_i.enemy,
                   (sense_i.sound || snd_memory)})
      4'b1???: nxt_o = BH_SPAWN;
      4'b01??: nxt_o = quiet_wander;
      4'b001?: nxt_o = seen_target;
      4'b0001: nxt_o = BH_CHASE;
      default: nxt_o = quiet_wander;
    endcase
  end
endmodule

// File: rtl/agent_state_reg.sv
module agent_state_reg
  import agent_pkg::*;
#(
  parameter bit ONEHOT_STATE = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  behav_e nxt_i,
  output behav_e cur_o
);
  generate
    if (ONEHOT_STATE) begin : g_onehot
      logic [NUM_BEHAV-1:0] oh_q;
      logic [NUM_BEHAV-1:0] oh_d;
      logic [STATE_W-1:0]   enc;

      always_comb begin
        oh_d = '0;
        oh_d[nxt_i] = 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) oh_q <= NUM_BEHAV'(1) << BH_WANDER;
        else         oh_q <= oh_d;
      end

      always_comb begin
        enc = '0;
        for (int i = 0; i < NUM_BEHAV; i++)
          if (oh_q[i]) enc = enc | STATE_W'(i);
      end

      assign cur_o = behav_e'(enc);
    end else begin : g_binary
      behav_e st_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= BH_WANDER;
        else         st_q <= nxt_i;
      end

      assign cur_o = st_q;
    end
  endgenerate
endmodule

// File: rtl/agent_action_decode.sv
module agent_action_decode
  import agent_pkg::*;
(
  input  behav_e cur_i,
  output act_t   act_o
);
  always_comb begin
    act_o = '0;
    unique case (cur_i)
      BH_WANDER, BH_WANDER_LOW:   act_o.wander  = 1'b1;
      BH_ATTACK, BH_ATTACK_SND:   act_o.attack  = 1'b1;
      BH_RETREAT, BH_RETREAT_SND: act_o.retreat = 1'b1;
      BH_CHASE:                   act_o.chase   = 1'b1;
      BH_SPAWN:                   act_o.spawn   = 1'b1;
      default:                    act_o         = '0;
    endcase
  end
endmodule

// File: rtl/agent_behavior_fsm.sv
module agent_behavior_fsm
  import agent_pkg::*;
#(
  parameter bit ONEHOT_STATE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enemy_seen_i,
  input  logic       sound_heard_i,
  input  logic       dead_i,
  input  logic       health_low_i,
  output logic [2:0] state_o,
  output logic       wander_o,
  output logic       attack_o,
  output logic       chase_o,
  output logic       retreat_o,
  output logic       spawn_o
);
  sense_t sense;
  behav_e cur_st;
  behav_e nxt_st;
  act_t   act;

  assign sense = '{enemy: enemy_seen_i, sound: sound_heard_i,
                   dead: dead_i, low: health_low_i};

  agent_next_state u_next (
    .cur_i   (cur_st),
    .sense_i (sense),
    .nxt_o   (nxt_st)
  );

  agent_state_reg #(.ONEHOT_STATE(ONEHOT_STATE)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt_st),
    .cur_o  (cur_st)
  );

  agent_action_decode u_dec (
    .cur_i (cur_st),
    .act_o (act)
  );

  assign state_o   = cur_st;
  assign wander_o  = act.wander;
  assign attack_o  = act.attack;
  assign chase_o   = act.chase;
  assign retreat_o = act.retreat;
  assign spawn_o   = act.spawn;
endmodule

// File: rtl/agent_behavior_chk.sv
module agent_behavior_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enemy_seen_i,
  input logic       sound_heard_i,
  input logic       dead_i,
  input logic       health_low_i,
  input logic [2:0] state_o,
  input logic       wander_o,
  input logic       attack_o,
  input logic       chase_o,
  input logic       retreat_o,
  input logic       spawn_o
);
  logic [4:0] acts;
  assign acts = {wander_o, attack_o, chase_o, retreat_o, spawn_o};

  AST_DEAD_SPAWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_i |=> (spawn_o && state_o == 3'd7)); // R4

  AST_SPAWN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spawn_o && !dead_i) |=> (wander_o && state_o == {2'b00, $past(health_low_i)})); // R8

  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(acts) == 1); // R9

  AST_ENEMY_ATTACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dead_i && !spawn_o && enemy_seen_i && !health_low_i) |=> attack_o); // R2

  AST_LOW_RETREAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dead_i && !spawn_o && enemy_seen_i && health_low_i) |=> retreat_o); // R6

  AST_SOUND_CHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dead_i && !spawn_o && !enemy_seen_i && sound_heard_i) |=> chase_o); // R3

  AST_SND_MEMORY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && !dead_i && !enemy_seen_i) |=> chase_o); // R5

  AST_QUIET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dead_i && !spawn_o && state_o != 3'd3 && !enemy_seen_i && !sound_heard_i
     && health_low_i) |=> (state_o == 3'd1)); // R7

  always_comb begin
    if (!rst_ni) AST_RESET_WANDER: assert (state_o == 3'd0 && wander_o); // R10
  end
endmodule

bind agent_behavior_fsm agent_behavior_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enemy_seen_i  (enemy_seen_i),
  .sound_heard_i (sound_heard_i),
  .dead_i        (dead_i),
  .health_low_i  (health_low_i),
  .state_o       (state_o),
  .wander_o      (wander_o),
  .attack_o      (attack_o),
  .chase_o       (chase_o),
  .retreat_o     (retreat_o),
  .spawn_o       (spawn_o)
);

// File: tb/agent_behavior_fsm_tb_top.sv
`timescale 1ns/1ps
module agent_behavior_fsm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enemy = 1'b0, sound = 1'b0, dead = 1'b0, low = 1'b0;

  logic [2:0] st_b, st_h;
  logic w_b, a_b, c_b, r_b, s_b;
  logic w_h, a_h, c_h, r_h, s_h;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit done = 1'b0;
  logic [2:0] exp_st;

  always #2 clk = ~clk;

  agent_behavior_fsm #(.ONEHOT_STATE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enemy_seen_i(enemy), .sound_heard_i(sound),
    .dead_i(dead), .health_low_i(low), .state_o(st_b), .wander_o(w_b),
    .attack_o(a_b), .chase_o(c_b), .retreat_o(r_b), .spawn_o(s_b));

  agent_behavior_fsm #(.ONEHOT_STATE(1'b1)) dut_oh_i (
    .clk_i(clk), .rst_ni(rst_n), .enemy_seen_i(enemy), .sound_heard_i(sound),
    .dead_i(dead), .health_low_i(low), .state_o(st_h), .wander_o(w_h),
    .attack_o(a_h), .chase_o(c_h), .retreat_o(r_h), .spawn_o(s_h));

  // codes: 0 wander, 1 wander-low, 2 attack, 3 attack+snd, 4 retreat,
  // 5 retreat+snd, 6 chase, 7 spawn
  function automatic logic [2:0] model(logic [2:0] c, bit e, bit s, bit d, bit l);
    if (d) return 3'd7;
    if (c == 3'd7) return l ? 3'd1 : 3'd0;
    if (e) begin
      if (l) return s ? 3'd5 : 3'd4;
      return (s || c == 3'd3) ? 3'd3 : 3'd2;
    end
    if (c == 3'd3 || s) return 3'd6;
    return l ? 3'd1 : 3'd0;
  endfunction

  // order {wander, attack, chase, retreat, spawn}
  function automatic logic [4:0] exp_act(logic [2:0] c);
    case (c)
      3'd0, 3'd1: return 5'b10000;
      3'd2, 3'd3: return 5'b01000;
      3'd4, 3'd5: return 5'b00010;
      3'd6:       return 5'b00100;
      default:    return 5'b00001;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R7";
      3'd2: return "R2";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag);
    logic [4:0] got_b, got_h;
    got_b = {w_b, a_b, c_b, r_b, s_b};
    got_h = {w_h, a_h, c_h, r_h, s_h};
    n_chk++;
    if (st_b !== exp_st || got_b !== exp_act(exp_st)) begin
      n_fail++;
      $display("FAIL %s: state/act %0d/%b expected %0d/%b", tag, st_b, got_b,
               exp_st, exp_act(exp_st));
    end
    n_chk++;
    if ($countones(got_b) != 1) begin
      n_fail++;
      $display("FAIL R9: act %b expected exactly one high", got_b);
    end
    n_chk++;
    if (st_h !== st_b || got_h !== got_b) begin
      n_fail++;
      $display("FAIL R11: onehot %0d/%b expected %0d/%b", st_h, got_h, st_b, got_b);
    end
  endtask

  // called just after a falling edge
  task automatic step(bit e, bit s, bit d, bit l, string tag);
    enemy = e; sound = s; dead = d; low = l;
    exp_st = model(exp_st, e, s, d, l);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h00c0ffee);
    exp_st = 3'd0;
    repeat (3) @(negedge clk);
    check("R10");
    rst_n = 1'b1;
    check("R10");

    step(0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, "R2");
    step(1, 1, 0, 0, "R5");
    step(1, 0, 0, 0, "R5");  // memory held without sound
    step(0, 0, 0, 0, "R5");  // straight to chase
    step(0, 0, 0, 0, "R1");
    step(1, 1, 0, 1, "R6");
    step(1, 0, 0, 1, "R6");
    step(0, 0, 0, 1, "R7");
    step(0, 1, 1, 1, "R4");
    step(1, 1, 1, 0, "R4");  // dead held in spawn
    step(1, 1, 0, 1, "R8");  // leaves to low wander, enemy ignored
    step(0, 1, 0, 0, "R3");
    step(1, 1, 0, 0, "R5");
    step(0, 0, 0, 1, "R5");  // memory beats low-health wander
    step(1, 0, 1, 0, "R4");
    step(1, 1, 0, 0, "R8");

    for (int i = 0; i < 4000; i++) begin
      bit e, s, d, l;
      logic [2:0] nx;
      e = $urandom_range(0, 1) == 1;
      s = $urandom_range(0, 2) == 0;
      d = $urandom_range(0, 15) == 0;
      l = $urandom_range(0, 3) == 0;
      nx = model(exp_st, e, s, d, l);
      step(e, s, d, l, (exp_st == 3'd7 && !d) ? "R8" : tag_of(nx));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule